// File: doc/BRIEF.md
# Microcoded Binary Adder with True/Complement Input

This unit is the arithmetic core of a control-word-driven datapath. It has two operand registers, a left one and a right one, and a single binary adder. A true/complement stage sits on the right input, so the same adder can add or subtract. Each control word can also refresh a two-bit condition code from the signed value of the result and write the sum back into the right operand register. The same word can latch a small constant for use by a later step.

Signed overflow is found the way a sequencer expects to branch on it. In a word numbered from the most significant bit down, it is the exclusive-or of the carries out of the two highest positions. It is kept as a registered flag beside the sum, so the next control word can pick a normal path or an error path.

The operand registers are loaded from a shared data input. A control word with its execute bit set launches one addition. All results are registered on the rising edge, and a synchronous reset clears them.

Top module: `mc_add_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every register clears to zero at that edge: `left_q`, `right_q`, `sum_q`, `ovf_q`, `cc_q` and `emit_q`.
- R2: At an edge where `ld_left` is high, `left_q` takes `din`. At an edge where `ld_right` is high and no write-back happens, `right_q` takes `din`.
- R3: Control-word bit 0 is the execute bit and bit 1 is the complement bit. Execute with complement clear makes `sum_q` equal to `left_q + right_q` modulo 2^W one edge later.
- R4: Execute with the complement bit set sends the inverted right operand into the adder with a carry-in of 1. One edge later, `sum_q` equals `left_q - right_q` modulo 2^W.
- R5: On execute, `ovf_q` takes the carry out of the top bit position XOR the carry out of the position just below it. This flag is 1 exactly when the signed result does not fit in W bits.
- R6: Control-word bit 2 enables the condition code. On execute with this bit set, `cc_q` takes 3 on overflow. Without overflow it takes 0 for a zero sum, 1 for a negative sum and 2 for a positive sum. Overflow takes priority over the sign.
- R7: If no execute with bit 2 set takes place at an edge, `cc_q` keeps its value.
- R8: Control-word bit 3 selects write-back. On execute with this bit set, `right_q` takes the new sum, and this wins over a `ld_right` in the same cycle.
- R9: Control-word bit 4 enables the emit capture. When it is set, `emit_q` takes bits 8:5 of the control word at that edge, whether or not the execute bit is set. Otherwise `emit_q` keeps its value.
- R10: In a cycle without execute, `sum_q` and `ovf_q` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_left | input | 1 | Load `din` into the left operand register |
| ld_right | input | 1 | Load `din` into the right operand register |
| din | input | W (32) | Operand load data |
| ctl_word | input | 9 | Control word: [0] execute, [1] complement, [2] set condition code, [3] write back, [4] emit enable, [8:5] emit value |
| left_q | output | W (32) | Left operand register |
| right_q | output | W (32) | Right operand register |
| sum_q | output | W (32) | Registered sum |
| ovf_q | output | 1 | Registered signed-overflow branch flag |
| cc_q | output | 2 | Condition code: 0 zero, 1 negative, 2 positive, 3 overflow |
| emit_q | output | 4 | Captured emit constant |

## Verification
An operand load shows on `left_q` or `right_q` one rising edge after the cycle that asserts it. The results of an execute cycle (`sum_q`, `ovf_q`, `cc_q`, the write-back into `right_q`, and the emit capture) all show one edge after the cycle that presents the control word.

The bench drives every input just after a falling edge and lets exactly one rising edge pass. It reads the outputs at the following falling edge, so each comparison sits one register stage after its stimulus. Hold behaviour is read in the same way, one edge after an idle or a cleared-enable cycle.

// File: rtl/mca_pkg.sv
`timescale 1ns/1ps
package mca_pkg;

    localparam int EMIT_W = 4;
    localparam int CW_W   = EMIT_W + 5;

    // Control word, MSB first: emit value, emit enable, write back,
    // set condition code, complement, execute.
    typedef struct packed {
        logic [EMIT_W-1:0] emit;
        logic              emit_en;
        logic              wb;
        logic              setcc;
        logic              comp;
        logic              go;
    } ctl_t;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2,
        CC_OVF  = 2'd3
    } cc_t;

endpackage

// File: rtl/mca_tc.sv
`timescale 1ns/1ps
module mca_tc #(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_in,
    input  logic         comp,
    output logic [W-1:0] opnd_out,
    output logic         carry_in
);
    // True/complement gating, one XOR per bit.
    for (genvar i = 0; i < W; i++) begin : g_tc
        assign opnd_out[i] = opnd_in[i] ^ comp;
    end

    // The +1 of a two's-complement subtract enters as the adder carry-in.
    assign carry_in = comp;
endmodule

// File: rtl/mca_ripple.sv
`timescale 1ns/1ps
module mca_ripple #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_top,
    output logic         c_next
);
    logic [W:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1]   = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    // Carry out of the most significant position, and out of the one below.
    assign c_top  = c[W];
    assign c_next = c[W-1];
endmodule

// File: rtl/mca_ccgen.sv
`timescale 1ns/1ps
module mca_ccgen
    import mca_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] sum,
    input  logic         ovf,
    output cc_t          code
);
    always_comb begin
        if (ovf) begin
            code = CC_OVF;
        end else if (sum == '0) begin
            code = CC_ZERO;
        end else if (sum[W-1]) begin
            code = CC_NEG;
        end else begin
            code = CC_POS;
        end
    end
endmodule

// File: rtl/mc_add_unit.sv
`timescale 1ns/1ps
module mc_add_unit
    import mca_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_left,
    input  logic                ld_right,
    input  logic [W-1:0]        din,
    input  logic [CW_W-1:0]     ctl_word,
    output logic [W-1:0]        left_q,
    output logic [W-1:0]        right_q,
    output logic [W-1:0]        sum_q,
    output logic                ovf_q,
    output logic [1:0]          cc_q,
    output logic [EMIT_W-1:0]   emit_q
);
    ctl_t         cw;
    logic [W-1:0] b_in;
    logic         cin;
    logic [W-1:0] sum_n;
    logic         c_top;
    logic         c_next;
    logic         ovf_n;
    cc_t          cc_n;

    assign cw = ctl_t'(ctl_word);

    mca_tc #(.W(W)) u_tc (
        .opnd_in  (right_q),
        .comp     (cw.comp),
        .opnd_out (b_in),
        .carry_in (cin)
    );

    mca_ripple #(.W(W)) u_add (
        .a      (left_q),
        .b      (b_in),
        .cin    (cin),
        .sum    (sum_n),
        .c_top  (c_top),
        .c_next (c_next)
    );

    assign ovf_n = c_top ^ c_next;

    mca_ccgen #(.W(W)) u_cc (
        .sum  (sum_n),
        .ovf  (ovf_n),
        .code (cc_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q  <= '0;
            right_q <= '0;
            sum_q   <= '0;
            ovf_q   <= 1'b0;
            cc_q    <= CC_ZERO;
            emit_q  <= '0;
        end else begin
            if (ld_left) begin
                left_q <= din;
            end
            if (cw.go && cw.wb) begin
                right_q <= sum_n;
            end else if (ld_right) begin
                right_q <= din;
            end
            if (cw.go) begin
                sum_q <= sum_n;
                ovf_q <= ovf_n;
                if (cw.setcc) begin
                    cc_q <= cc_n;
                end
            end
            if (cw.emit_en) begin
                emit_q <= cw.emit;
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (left_q == '0 && right_q == '0 && sum_q == '0 &&
                 !ovf_q && cc_q == 2'd0 && emit_q == '0));

    assert_load_left_R2: assert property (@(posedge clk) disable iff (rst)
        ld_left |=> left_q == $past(din));

    assert_add_R3: assert property (@(posedge clk) disable iff (rst)
        (cw.go && !cw.comp) |=> sum_q == $past(left_q + right_q));

    assert_sub_R4: assert property (@(posedge clk) disable iff (rst)
        (cw.go && cw.comp) |=> sum_q == $past(left_q - right_q));

    assert_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        cw.go |=> ovf_q == (($past(left_q[W-1]) == $past(right_q[W-1] ^ cw.comp)) &&
                            (sum_q[W-1] != $past(left_q[W-1]))));

    assert_ovf_priority_R6: assert property (@(posedge clk) disable iff (rst)
        (cw.go && cw.setcc) |=> (ovf_q ? (cc_q == 2'd3) : (cc_q != 2'd3)));

    assert_cc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(cw.go && cw.setcc) |=> $stable(cc_q));

    assert_writeback_R8: assert property (@(posedge clk) disable iff (rst)
        (cw.go && cw.wb) |=> right_q == sum_q);

    assert_emit_R9: assert property (@(posedge clk) disable iff (rst)
        cw.emit_en |=> emit_q == $past(cw.emit));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !cw.go |=> ($stable(sum_q) && $stable(ovf_q)));
endmodule

// File: tb/mc_add_unit_test.sv
`timescale 1ns/1ps
module mc_add_unit_test;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_left = 1'b0;
    logic          ld_right = 1'b0;
    logic [W-1:0]  din = '0;
    logic [8:0]    ctl_word = '0;
    logic [W-1:0]  left_q, right_q, sum_q;
    logic          ovf_q;
    logic [1:0]    cc_q;
    logic [3:0]    emit_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] right_m;
    logic [W-1:0] sum_m;
    logic         ovf_m;
    logic [1:0]   cc_m;
    logic [3:0]   emit_m;

    always #2 clk = ~clk;

    mc_add_unit #(.W(W)) uut (
        .clk(clk), .rst(rst), .ld_left(ld_left), .ld_right(ld_right),
        .din(din), .ctl_word(ctl_word), .left_q(left_q), .right_q(right_q),
        .sum_q(sum_q), .ovf_q(ovf_q), .cc_q(cc_q), .emit_q(emit_q)
    );

    function automatic logic [W-1:0] f_sum(logic [W-1:0] l, logic [W-1:0] r, logic c);
        return c ? (l - r) : (l + r);
    endfunction

    function automatic logic f_ovf(logic [W-1:0] l, logic [W-1:0] r, logic c);
        logic signed [W:0] x;
        x = c ? ($signed({l[W-1], l}) - $signed({r[W-1], r}))
              : ($signed({l[W-1], l}) + $signed({r[W-1], r}));
        return x[W] != x[W-1];
    endfunction

    function automatic logic [1:0] f_cc(logic [W-1:0] s, logic o);
        if (o) return 2'd3;
        if (s == '0) return 2'd0;
        if (s[W-1]) return 2'd1;
        return 2'd2;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Load both operands, execute one control word, check all results.
    task automatic run_op(input logic [W-1:0] l, input logic [W-1:0] r,
                          input logic comp, input logic setcc, input logic wb,
                          input logic emen, input logic [3:0] em, input logic clash);
        ld_left = 1'b1; din = l; step(); ld_left = 1'b0;
        chk("R2 left load", left_q, l);
        ld_right = 1'b1; din = r; step(); ld_right = 1'b0;
        chk("R2 right load", right_q, r);
        ctl_word = {em, emen, wb, setcc, comp, 1'b1};
        if (clash) begin ld_right = 1'b1; din = ~r; end
        step();
        ctl_word = '0; ld_right = 1'b0;
        sum_m = f_sum(l, r, comp);
        ovf_m = f_ovf(l, r, comp);
        if (setcc) cc_m = f_cc(sum_m, ovf_m);
        if (emen) emit_m = em;
        right_m = wb ? sum_m : (clash ? ~r : r);
        chk(comp ? "R4 difference" : "R3 sum", sum_q, sum_m);
        chk("R5 overflow", {31'd0, ovf_q}, {31'd0, ovf_m});
        chk(setcc ? "R6 condition code" : "R7 cc hold", {30'd0, cc_q}, {30'd0, cc_m});
        chk("R8 right after exec", right_q, right_m);
        chk("R9 emit", {28'd0, emit_q}, {28'd0, emit_m});
    endtask

    function automatic logic [W-1:0] pick();
        case ($urandom() % 8)
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'h0000_0000;
            3: return 32'hFFFF_FFFF;
            4: return 32'h0000_0001;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk); step();
        // R1: reset state
        chk("R1 left", left_q, '0);
        chk("R1 right", right_q, '0);
        chk("R1 sum", sum_q, '0);
        chk("R1 ovf", {31'd0, ovf_q}, '0);
        chk("R1 cc", {30'd0, cc_q}, '0);
        chk("R1 emit", {28'd0, emit_q}, '0);
        rst = 1'b0;
        cc_m = 2'd0; emit_m = 4'd0;

        // Directed corners
        run_op(32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1, 1'b0, 1'b1, 4'h8, 1'b0); // R5 R6 overflow
        run_op(32'h8000_0000, 32'h1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h3, 1'b0); // R4 overflow
        run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0); // zero sum, cc 3
        run_op(32'd5, 32'd5, 1'b1, 1'b1, 1'b1, 1'b1, 4'hA, 1'b0); // R6 zero, R8
        run_op(32'd3, 32'd9, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0); // R6 negative
        run_op(32'd9, 32'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0); // R6 positive
        run_op(32'd1, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0); // R7 hold
        run_op(32'h1234, 32'h10, 1'b0, 1'b1, 1'b1, 1'b1, 4'h5, 1'b1); // R8 wins over load
        run_op(32'h1234, 32'h10, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b1); // R2 load without wb

        // R10: idle cycle with new left load; R9: emit without execute
        ld_left = 1'b1; din = 32'hDEAD_BEEF; ctl_word = {4'hC, 1'b1, 4'b0000};
        step(); ld_left = 1'b0; ctl_word = '0;
        emit_m = 4'hC;
        chk("R10 sum hold", sum_q, sum_m);
        chk("R10 ovf hold", {31'd0, ovf_q}, {31'd0, ovf_m});
        chk("R2 left during idle", left_q, 32'hDEAD_BEEF);
        chk("R9 emit without execute", {28'd0, emit_q}, {28'd0, emit_m});
        chk("R7 cc idle hold", {30'd0, cc_q}, {30'd0, cc_m});

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] a, b;
            logic [8:0] rb;
            a = pick(); b = pick(); rb = 9'($urandom());
            run_op(a, b, rb[1], rb[2], rb[3], rb[4], rb[8:5], rb[0]);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule